// File: doc/BRIEF.md
# UART Interrupt Status and Routing Controller

This block keeps the raw interrupt status of a UART and turns it into interrupt lines for the rest of the chip. Eleven event sources (four modem-status lines, receive, transmit, receive timeout and four receive-error kinds) each set their own status bit through a one-cycle pulse. Transmit is also set whenever software writes a character to the data word. Software programs an enable mask, reads the raw and the enabled status, and acknowledges events by writing a mask of bits to clear. The bus port has separate read and write strobes, a word address and registered read data.

Six registered interrupt lines come out. One is the combined request, high when any enabled source is pending. The other five are narrower: receive, transmit, receive timeout, the modem group and the error group. Each line is high when the raw status ANDed with the enable mask has a non-zero bit inside that line's group. The lines follow status and enable changes one clock later.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Status bit positions are fixed: ring indicator 0, CTS 1, DCD 2, DSR 3, receive 4, transmit 5, receive timeout 6, framing 7, parity 8, break 9, overrun 10. A pulse on `src_set_i[k]` sets status bit k at the next clock edge.
- R2: A bus write to word address 0 (data word) sets the transmit status bit (bit 5).
- R3: A bus write to word address 17 clears every status bit whose write-data bit is 1 and leaves the others unchanged.
- R4: When a set pulse and a clear write reach the same bit in the same cycle, the bit ends up set.
- R5: Word address 14 writes and reads the enable mask; only write-data bits 10:0 are stored, and read bits above 10 are zero.
- R6: A read strobe at word 15 returns the raw status and at word 16 the raw status ANDed with the enable mask, in bits 10:0; read data appears on `bus_rdata_o` after the clock edge that samples the strobe and holds until the next read. Any other word address reads as zero.
- R7: `irq_o` bit order and groups: bit 0 combined (status bits 10:0), bit 1 receive (bit 4), bit 2 transmit (bit 5), bit 3 receive timeout (bit 6), bit 4 modem group (bits 3:0), bit 5 error group (bits 10:7). A line is high when status AND enable has a set bit in its group.
- R8: `irq_o` is registered: it reflects the status and enable values stored at the previous clock edge, so it changes one cycle after them.
- R9: Reset clears status, enable, `irq_o` and read data to zero.
- R10: Writes to word addresses other than 0, 14 and 17 (including the read-only 15 and 16) change neither status nor enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_set_i | input | 11 | One-cycle set pulses, one per status bit |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | 8 | Word address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Registered read data |
| irq_o | output | 6 | Interrupt lines: combined, receive, transmit, timeout, modem, error |

## Verification
The enable mask is swept over all 2048 values with every status bit pending, so each output line and the masked-status read are seen to depend on exactly the enable bits of their group. The status is then swept over all 2048 patterns with the mask fully open, each pattern loaded by a clear-all write in the same cycle as its set pulses, which tells apart a correct set-over-clear priority from a clear that wins or a bit that leaks. Directed cases cover a partial clear, the transmit set from a data write, writes to read-only and unmapped words, a wide enable write and the one-cycle output lag after a set pulse.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int NUM_SRC = 11;
    localparam int NUM_OUT = 6;

    // status bit positions
    localparam int B_RING    = 0;
    localparam int B_CTS     = 1;
    localparam int B_DCD     = 2;
    localparam int B_DSR     = 3;
    localparam int B_RX      = 4;
    localparam int B_TX      = 5;
    localparam int B_TIMEOUT = 6;
    localparam int B_FRAME   = 7;
    localparam int B_PARITY  = 8;
    localparam int B_BREAK   = 9;
    localparam int B_OVERRUN = 10;

    typedef logic [NUM_SRC-1:0] src_vec_t;
    typedef logic [NUM_OUT-1:0] irq_vec_t;

    function automatic src_vec_t bit_at(input int pos);
        src_vec_t v;
        v = '0;
        v[pos] = 1'b1;
        return v;
    endfunction

    // group covered by each output line, in output order
    function automatic src_vec_t line_group(input int line);
        src_vec_t g;
        case (line)
            0:       g = '1;
            1:       g = bit_at(B_RX);
            2:       g = bit_at(B_TX);
            3:       g = bit_at(B_TIMEOUT);
            4:       g = bit_at(B_RING) | bit_at(B_CTS) | bit_at(B_DCD) | bit_at(B_DSR);
            default: g = bit_at(B_FRAME) | bit_at(B_PARITY) | bit_at(B_BREAK) | bit_at(B_OVERRUN);
        endcase
        return g;
    endfunction

endpackage

// File: rtl/uart_irq_regif.sv
module uart_irq_regif
    import uart_irq_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter int                DATA_W      = 16,
    parameter logic [ADDR_W-1:0] ADDR_DATA   = ADDR_W'(0),
    parameter logic [ADDR_W-1:0] ADDR_ENABLE = ADDR_W'(14),
    parameter logic [ADDR_W-1:0] ADDR_RAW    = ADDR_W'(15),
    parameter logic [ADDR_W-1:0] ADDR_MASKED = ADDR_W'(16),
    parameter logic [ADDR_W-1:0] ADDR_CLEAR  = ADDR_W'(17)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  src_vec_t          wdata_i,
    input  src_vec_t          status_i,
    input  src_vec_t          enable_i,
    output logic              tx_set_o,
    output logic              en_we_o,
    output src_vec_t          en_val_o,
    output src_vec_t          clr_mask_o,
    output logic [DATA_W-1:0] rdata_o
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rif_state_t;

    rif_state_t st_d, st_q;
    src_vec_t   rd_word;

    // write decode
    always_comb begin
        tx_set_o   = wr_i && (addr_i == ADDR_DATA);
        en_we_o    = wr_i && (addr_i == ADDR_ENABLE);
        en_val_o   = wdata_i;
        clr_mask_o = (wr_i && (addr_i == ADDR_CLEAR)) ? wdata_i : '0;
    end

    // read mux and next state
    always_comb begin
        if (addr_i == ADDR_ENABLE)      rd_word = enable_i;
        else if (addr_i == ADDR_RAW)    rd_word = status_i;
        else if (addr_i == ADDR_MASKED) rd_word = status_i & enable_i;
        else                            rd_word = '0;

        st_d = st_q;
        if (rd_i) st_d.rdata = DATA_W'(rd_word);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata_o = st_q.rdata;

    // R6: read data only moves on a read strobe
    a_r6_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(rdata_o));

    // R6: bits above the status width always read zero
    a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_o >> NUM_SRC) == '0);

    // R2: a transmit set only comes from a write strobe
    a_r2_tx_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        tx_set_o |-> wr_i);

endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
    import uart_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t set_i,
    input  src_vec_t clr_i,
    output src_vec_t status_o
);

    typedef struct packed {
        src_vec_t raw;
    } sts_state_t;

    sts_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        // set applied after clear, so set wins on a collision
        st_d.raw = (st_q.raw & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.raw;

    // R1: every pulsed bit is set after the edge
    a_r1_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((status_o & $past(set_i)) == $past(set_i)));

    // R3: a cleared bit without a set is low after the edge
    a_r3_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_i) |=> ((status_o & $past(clr_i & ~set_i)) == '0));

    // R3: bits neither set nor cleared keep their value
    a_r3_others_kept: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((status_o ^ $past(status_o)) & ~$past(set_i | clr_i)) == '0));

    // R4: set beats clear on the same bit
    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_i & clr_i)) |=> ((status_o & $past(set_i & clr_i)) == $past(set_i & clr_i)));

endmodule

// File: rtl/uart_irq_enable.sv
module uart_irq_enable
    import uart_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     we_i,
    input  src_vec_t val_i,
    output src_vec_t enable_o
);

    typedef struct packed {
        src_vec_t mask;
    } en_state_t;

    en_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) st_d.mask = val_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign enable_o = st_q.mask;

    // R5: a write loads the mask
    a_r5_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (enable_o == $past(val_i)));

    // R10: without a write the mask holds
    a_r10_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(enable_o));

endmodule

// File: rtl/uart_irq_lines.sv
module uart_irq_lines
    import uart_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t status_i,
    input  src_vec_t enable_i,
    output irq_vec_t irq_o
);

    typedef struct packed {
        irq_vec_t lines;
    } ln_state_t;

    ln_state_t st_d, st_q;
    src_vec_t  pending;
    irq_vec_t  line_hit;

    assign pending = status_i & enable_i;

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_line
        localparam src_vec_t GMASK = line_group(g);
        assign line_hit[g] = |(pending & GMASK);
    end

    always_comb begin
        st_d       = st_q;
        st_d.lines = line_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.lines;

    // R7: any narrow line implies the combined line
    a_r7_combined_covers: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_o[NUM_OUT-1:1]) |-> irq_o[0]);

    // R8: outputs only move one cycle after an input change
    a_r8_registered: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(status_i) && $stable(enable_i)) |=> $stable(irq_o));

    // R9: nothing pending, nothing raised next cycle
    a_r9_quiet_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (pending == '0) |=> (irq_o == '0));

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [10:0]       src_set_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic [5:0]        irq_o
);

    src_vec_t status, enable, en_val, clr_mask, set_all;
    logic     tx_set, en_we;
    logic     unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata_i;

    assign set_all = src_set_i | (tx_set ? bit_at(B_TX) : '0);

    uart_irq_regif #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regif (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (bus_wr_i),
        .rd_i       (bus_rd_i),
        .addr_i     (bus_addr_i),
        .wdata_i    (bus_wdata_i[NUM_SRC-1:0]),
        .status_i   (status),
        .enable_i   (enable),
        .tx_set_o   (tx_set),
        .en_we_o    (en_we),
        .en_val_o   (en_val),
        .clr_mask_o (clr_mask),
        .rdata_o    (bus_rdata_o)
    );

    uart_irq_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_all),
        .clr_i    (clr_mask),
        .status_o (status)
    );

    uart_irq_enable u_enable (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (en_we),
        .val_i    (en_val),
        .enable_o (enable)
    );

    uart_irq_lines u_lines (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_i (status),
        .enable_i (enable),
        .irq_o    (irq_o)
    );

    // R2: a data-word write raises transmit on the next edge
    a_r2_tx_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == '0) |=> status[B_TX]);

endmodule

// File: tb/uart_irq_ctrl_tb.sv
module uart_irq_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] src_set_i = '0;
    logic        bus_wr_i = 1'b0;
    logic        bus_rd_i = 1'b0;
    logic [7:0]  bus_addr_i = '0;
    logic [15:0] bus_wdata_i = '0;
    logic [15:0] bus_rdata_o;
    logic [5:0]  irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;   // 250 MHz

    uart_irq_ctrl u_dut (.*);

    function automatic logic [5:0] exp_irq(input logic [10:0] s, input logic [10:0] e);
        logic [10:0] p;
        logic [5:0]  r;
        p = s & e;
        r[0] = (p & 11'h7FF) != 0;
        r[1] = (p & 11'h010) != 0;
        r[2] = (p & 11'h020) != 0;
        r[3] = (p & 11'h040) != 0;
        r[4] = (p & 11'h00F) != 0;
        r[5] = (p & 11'h780) != 0;
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
        bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk);
        bus_wr_i = 1'b0; bus_wdata_i = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [15:0] d);
        bus_rd_i = 1'b1; bus_addr_i = a;
        @(negedge clk);
        bus_rd_i = 1'b0;
        d = bus_rdata_o;
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        logic [15:0] rd;
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 irq after reset", irq_o, 0);
        check("R9 rdata after reset", bus_rdata_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        bus_read(8'd14, rd); check("R9 enable after reset", rd, 0);
        bus_read(8'd15, rd); check("R9 status after reset", rd, 0);

        // R5: wide enable write keeps 11 bits
        bus_write(8'd14, 16'hFFFF);
        bus_read(8'd14, rd); check("R5 enable readback", rd, 16'h07FF);

        // R8: one-cycle lag after a receive pulse
        src_set_i = 11'h010;
        @(negedge clk);
        src_set_i = '0;
        check("R8 irq not yet", irq_o, 0);
        @(negedge clk);
        check("R8 R1 irq after lag", irq_o, 6'b000011);

        // R6: read holds without strobe, unmapped reads zero
        bus_read(8'd15, rd); check("R6 raw read", rd, 16'h0010);
        @(negedge clk); @(negedge clk);
        check("R6 rdata held", bus_rdata_o, 16'h0010);
        bus_read(8'd20, rd); check("R6 unmapped read", rd, 0);

        // R2: data write sets transmit
        bus_write(8'd0, 16'h0041);
        @(negedge clk);
        check("R2 irq transmit", irq_o, 6'b000111);
        bus_read(8'd15, rd); check("R2 raw has tx", rd, 16'h0030);

        // R3: partial clear
        src_set_i = 11'h7FF; @(negedge clk); src_set_i = '0;
        bus_write(8'd17, 16'h00A5);
        bus_read(8'd15, rd); check("R3 partial clear", rd, 16'h075A);

        // R10: writes to read-only and unmapped words
        bus_write(8'd15, 16'hFFFF);
        bus_write(8'd16, 16'hFFFF);
        bus_write(8'd3,  16'hFFFF);
        bus_read(8'd15, rd); check("R10 status untouched", rd, 16'h075A);
        bus_read(8'd14, rd); check("R10 enable untouched", rd, 16'h07FF);

        // R7: enable sweep with all status pending
        src_set_i = 11'h7FF; @(negedge clk); src_set_i = '0;
        for (int e = 0; e < 2048; e++) begin
            bus_write(8'd14, 16'(e));
            @(negedge clk);
            check("R7 irq vs enable", irq_o, exp_irq(11'h7FF, 11'(e)));
            bus_read(8'd16, rd); check("R6 masked read", rd, 16'(e));
        end

        // R4 R1: status sweep, clear-all plus set in the same cycle
        bus_write(8'd14, 16'h07FF);
        for (int p = 0; p < 2048; p++) begin
            src_set_i = 11'(p);
            bus_write(8'd17, 16'h07FF);
            src_set_i = '0;
            @(negedge clk);
            check("R7 irq vs status", irq_o, exp_irq(11'(p), 11'h7FF));
            bus_read(8'd15, rd); check("R4 set wins raw", rd, 16'(p));
        end

        done = 1;
        report();
    end

endmodule